// File: doc/BRIEF.md
# Reshapeable Two-Clock Block Memory

This block is a simple dual-port memory holding a fixed array of 1,152 bits. One port only writes and the other only reads, and each port runs on its own clock. A two-bit shape input sets how the array is seen as words: a few wide words or many narrow ones. Every shape is laid over the same linear bit array, so data written in one shape can be read back in another through a fixed arithmetic mapping.

Writes happen on the write clock edge while the write enable is high. The read side works in one of two ways, chosen by a static select input. In the registered form the word is captured on the read clock edge while the read enable is high, and it holds otherwise. In the combinational form the read data follows the read address and the array contents directly, with no clock involved. The address and data buses are sized for the deepest and widest shapes. Narrower shapes use only the low bits.

An active-low reset clears the registered read data. The array contents are not reset.

Top module: `aspect_dpram`

## Requirements
- R1: The 2-bit `shape_mode` input selects the word shape: 00 = 64 words x 18 bits, 01 = 128 x 9, 10 = 256 x 4, 11 = 512 x 2. Each shape stores and returns its own word width.
- R2: A write takes place on the rising edge of `wr_clk` only while `wr_en` is 1. A cycle with `wr_en` at 0 leaves every stored bit unchanged.
- R3: In a shape of width W, the word at address A occupies bits A*W through A*W+W-1 of one linear 1,152-bit array. Bit k of the word is array bit A*W+k. Data written in one shape reads back through this mapping in any other shape.
- R4: Address bits at or above log2(depth) of the current shape are ignored. For example, in shape 01 the addresses A, A|0x80 and A|0x100 reach the same word.
- R5: Read-data bits at or above the current word width read as 0.
- R6: Write-data bits at or above the current word width are ignored and never disturb neighbouring words.
- R7: With `rd_async` at 0, a rising edge of `rd_clk` while `rd_en` is 1 loads the word at `rd_addr` into `rd_data`. The new value is visible after that edge.
- R8: With `rd_async` at 0 and `rd_en` at 0, `rd_data` holds its value across `rd_clk` edges, even if `rd_addr` or the addressed word changes.
- R9: With `rd_async` at 1, `rd_data` follows `rd_addr` and the array contents combinationally, without any `rd_clk` edge.
- R10: A read of an address after a write to it returns the newly written data.
- R11: While `rst_n` is 0, the registered read data is 0. The stored array is kept through the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low asynchronous clear of the registered read data |
| shape_mode | input | 2 | Word shape select (static during use) |
| rd_async | input | 1 | 1 = combinational read, 0 = registered read |
| wr_clk | input | 1 | Write port clock |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 9 | Write word address (low bits used in shallow shapes) |
| wr_data | input | 18 | Write data (low bits used in narrow shapes) |
| rd_clk | input | 1 | Read port clock |
| rd_en | input | 1 | Read enable for the registered read |
| rd_addr | input | 9 | Read word address |
| rd_data | output | 18 | Read data, upper bits zero in narrow shapes |

## Verification
The bench fills the array in the two shapes that cover all 1,152 bits. It then reads every word back in all four shapes against a bit-level reference array. A wrong base multiplier or lane mask shows up as a wrong word or as corrupted neighbours when a narrow-shape write carries junk in its upper data bits. Writes and reads use addresses with high bits set beyond the shape's depth. A design that did not mask those bits would either read outside the array or alias the word wrongly. The bench also writes the word that a held read register came from while the read enable is low. A design that registered the address instead of the data would leak the new contents. It pulls reset in the middle of a run to show that only the read register clears and the array survives.

// File: rtl/aspect_pkg.sv
package aspect_pkg;

    // Default geometry: widest word and deepest address
    localparam int DEF_DATA_W = 18;
    localparam int DEF_ADDR_W = 9;
    // log2 of (deepest depth / shallowest depth)
    localparam int SHAPE_SPAN = 3;

    typedef enum logic [1:0] {
        SHAPE_WIDEST   = 2'b00,  // 64 x 18
        SHAPE_WIDE     = 2'b01,  // 128 x 9
        SHAPE_NARROW   = 2'b10,  // 256 x 4
        SHAPE_NARROWEST = 2'b11  // 512 x 2
    } shape_e;

endpackage

// File: rtl/aspect_lane_map.sv
module aspect_lane_map
    import aspect_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int IDX_W  = 11
) (
    input  shape_e              shape,
    input  logic [ADDR_W-1:0]   addr,
    output logic [IDX_W-1:0]    base,
    output logic [DATA_W-1:0]   lanes
);

    localparam int LOG_BASE_DEPTH = ADDR_W - SHAPE_SPAN;

    int                  width;
    logic [ADDR_W-1:0]   amask;

    // Word width halves per shape step; depth doubles per shape step.
    always_comb begin
        width = DATA_W >> shape;
        lanes = DATA_W'((64'd1 << width) - 64'd1);
        amask = ADDR_W'((32'd1 << (LOG_BASE_DEPTH + int'(shape))) - 32'd1);
        base  = IDX_W'(addr & amask) * IDX_W'(width);
    end

endmodule

// File: rtl/aspect_bit_array.sv
module aspect_bit_array #(
    parameter int DATA_W     = 18,
    parameter int ARRAY_BITS = 1152,
    parameter int IDX_W      = 11
) (
    input  logic                 wr_clk,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_base,
    input  logic [DATA_W-1:0]    wr_lanes,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [IDX_W-1:0]     rd_base,
    input  logic [DATA_W-1:0]    rd_lanes,
    output logic [DATA_W-1:0]    rd_word
);

    logic [ARRAY_BITS-1:0] bits_q;
    logic [ARRAY_BITS-1:0] put_mask;
    logic [ARRAY_BITS-1:0] put_vec;

    // Place the active lanes of the incoming word at its linear position
    always_comb begin
        put_mask = ARRAY_BITS'(wr_lanes) << wr_base;
        put_vec  = ARRAY_BITS'(wr_data & wr_lanes) << wr_base;
    end

    always_ff @(posedge wr_clk) begin
        if (wr_en) begin
            bits_q <= (bits_q & ~put_mask) | put_vec;
        end
    end

    // Pull the addressed word down to bit 0, drop unused lanes
    always_comb begin
        rd_word = DATA_W'(bits_q >> rd_base) & rd_lanes;
    end

endmodule

// File: rtl/aspect_read_stage.sv
module aspect_read_stage #(
    parameter int DATA_W = 18
) (
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              rd_async,
    input  logic [DATA_W-1:0] word_in,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] held_q;

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (rd_en) begin
            held_q <= word_in;
        end
    end

    always_comb begin
        rd_data = rd_async ? word_in : held_q;
    end

endmodule

// File: rtl/aspect_dpram.sv
module aspect_dpram
    import aspect_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic              rst_n,
    input  logic [1:0]        shape_mode,
    input  logic              rd_async,
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int ARRAY_BITS = DATA_W << (ADDR_W - SHAPE_SPAN);
    localparam int IDX_W      = $clog2(ARRAY_BITS);
    localparam int N_PORTS    = 2;  // 0 = write side, 1 = read side

    shape_e             shape_sel;
    logic [ADDR_W-1:0]  port_addr  [N_PORTS];
    logic [IDX_W-1:0]   port_base  [N_PORTS];
    logic [DATA_W-1:0]  port_lanes [N_PORTS];
    logic [DATA_W-1:0]  word_now;

    assign shape_sel    = shape_e'(shape_mode);
    assign port_addr[0] = wr_addr;
    assign port_addr[1] = rd_addr;

    // One address-to-lane map per port
    for (genvar p = 0; p < N_PORTS; p++) begin : g_map
        aspect_lane_map #(
            .DATA_W (DATA_W),
            .ADDR_W (ADDR_W),
            .IDX_W  (IDX_W)
        ) map_i (
            .shape (shape_sel),
            .addr  (port_addr[p]),
            .base  (port_base[p]),
            .lanes (port_lanes[p])
        );
    end

    aspect_bit_array #(
        .DATA_W     (DATA_W),
        .ARRAY_BITS (ARRAY_BITS),
        .IDX_W      (IDX_W)
    ) array_i (
        .wr_clk   (wr_clk),
        .wr_en    (wr_en),
        .wr_base  (port_base[0]),
        .wr_lanes (port_lanes[0]),
        .wr_data  (wr_data),
        .rd_base  (port_base[1]),
        .rd_lanes (port_lanes[1]),
        .rd_word  (word_now)
    );

    aspect_read_stage #(
        .DATA_W (DATA_W)
    ) rstage_i (
        .rd_clk   (rd_clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_async (rd_async),
        .word_in  (word_now),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/aspect_dpram_chk.sv
module aspect_dpram_chk #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 9
) (
    input logic              rst_n,
    input logic [1:0]        shape_mode,
    input logic              rd_async,
    input logic              wr_clk,
    input logic              wr_en,
    input logic              rd_clk,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data
);

    // Counts accepted writes so the read side can tell if the array moved
    logic [7:0] wr_seen;
    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_seen <= '0;
        end else if (wr_en) begin
            wr_seen <= wr_seen + 8'd1;
        end
    end

    // R8: registered output holds when the previous edge had no read enable
    a_r8_hold_when_idle: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!rd_async && !$past(rd_async) && !$past(rd_en)) |-> $stable(rd_data));

    // R5: unused upper lanes are zero on the combinational read
    a_r5_upper_zero: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_async |-> ((rd_data >> (DATA_W >> shape_mode)) == '0));

    // R9: combinational read is steady if address, shape and array are steady
    a_r9_async_steady: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_async && $past(rd_async) && $stable(rd_addr) && $stable(shape_mode)
         && $stable(wr_seen)) |-> $stable(rd_data));

    // R11: registered read data is zero throughout reset
    a_r11_reset_clear: assert property (@(posedge rd_clk)
        (!rst_n && !rd_async) |-> (rd_data == '0));

endmodule

bind aspect_dpram aspect_dpram_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .rst_n      (rst_n),
    .shape_mode (shape_mode),
    .rd_async   (rd_async),
    .wr_clk     (wr_clk),
    .wr_en      (wr_en),
    .rd_clk     (rd_clk),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data)
);

// File: tb/aspect_dpram_tb_top.sv
`timescale 1ns/1ps
module aspect_dpram_tb_top;

    logic        rst_n = 1'b0;
    logic [1:0]  shape_mode = 2'b00;
    logic        rd_async = 1'b0;
    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [8:0]  rd_addr = '0;
    logic [17:0] wr_data = '0;
    logic [17:0] rd_data;

    int n_total = 0;
    int n_bad   = 0;
    logic [1151:0] model;

    // 200 MHz on both ports, read clock offset by a quarter period
    always #2.5 wr_clk = ~wr_clk;
    initial begin
        #1.25;
        forever #2.5 rd_clk = ~rd_clk;
    end

    aspect_dpram dut_i (
        .rst_n      (rst_n),
        .shape_mode (shape_mode),
        .rd_async   (rd_async),
        .wr_clk     (wr_clk),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_clk     (rd_clk),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );

    function automatic logic [17:0] pat(int a, int salt);
        return 18'(a * 9973 + salt * 40507 + 3);
    endfunction

    // Expected word from the linear bit model: base = (A mod depth) * W
    function automatic logic [17:0] expect_word(int s, int a);
        int w = 18 >> s;
        int b = (a % (64 << s)) * w;
        logic [17:0] r = '0;
        for (int k = 0; k < w; k++) r[k] = model[b + k];
        return r;
    endfunction

    task automatic model_put(int s, int a, logic [17:0] d);
        int w = 18 >> s;
        int b = (a % (64 << s)) * w;
        for (int k = 0; k < w; k++) model[b + k] = d[k];
    endtask

    task automatic check(string tag, logic [17:0] got, logic [17:0] exp);
        n_total++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    endtask

    task automatic put(int a, logic [17:0] d);
        @(negedge wr_clk);
        wr_en   = 1'b1;
        wr_addr = 9'(a);
        wr_data = d;
        @(negedge wr_clk);
        wr_en   = 1'b0;
        model_put(int'(shape_mode), a, d);
    endtask

    task automatic get_sync(int a, output logic [17:0] v);
        @(negedge rd_clk);
        rd_en   = 1'b1;
        rd_addr = 9'(a);
        @(negedge rd_clk);
        rd_en   = 1'b0;
        #0.1;
        v = rd_data;
    endtask

    task automatic get_async(int a, output logic [17:0] v);
        rd_addr = 9'(a);
        #0.5;
        v = rd_data;
    endtask

    task automatic set_shape(int s);
        @(negedge wr_clk);
        shape_mode = 2'(s);
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [17:0] v;
        logic [17:0] keep;

        // R11: reset state of the registered read data
        repeat (3) @(negedge wr_clk);
        check("R11 reset clears read data", rd_data, 18'h0);
        @(negedge rd_clk);
        rst_n = 1'b1;

        // R1 R2 R7: shape 00, fill all 64 words and read back registered
        set_shape(0);
        for (int a = 0; a < 64; a++) put(a, pat(a, 1));
        for (int a = 0; a < 64; a++) begin
            get_sync(a, v);
            check($sformatf("R7 R1 shape00 sync a=%0d", a), v, expect_word(0, a));
        end

        // R4 R6: shape 01 writes with aliased address and junk upper data
        set_shape(1);
        for (int a = 0; a < 128; a++)
            put(a | ((a % 2 == 1) ? 9'h100 : 9'h080), pat(a, 2) | 18'h3FE00);

        // R9 R5 R3 R4: combinational reads with another alias of the address
        rd_async = 1'b1;
        for (int a = 0; a < 128; a++) begin
            get_async(a | 9'h180, v);
            check($sformatf("R9 R5 R4 shape01 async a=%0d", a), v, expect_word(1, a));
        end
        rd_async = 1'b0;

        // R3: read words written as 9-bit in the 18-bit shape
        set_shape(0);
        for (int a = 0; a < 64; a++) begin
            get_sync(a, v);
            check($sformatf("R3 cross shape00 a=%0d", a), v, expect_word(0, a));
        end

        // R3 R5: shape 10 reads of the same bits, registered path
        set_shape(2);
        for (int a = 0; a < 256; a++) begin
            get_sync(a, v);
            check($sformatf("R3 R5 shape10 sync a=%0d", a), v, expect_word(2, a));
        end

        // R1 R6: shape 10 writes, then combinational readback
        for (int a = 0; a < 256; a++) put(a, pat(a, 3));
        rd_async = 1'b1;
        for (int a = 0; a < 256; a++) begin
            get_async(a, v);
            check($sformatf("R1 R6 shape10 async a=%0d", a), v, expect_word(2, a));
        end

        // R1: shape 11 full sweep
        set_shape(3);
        for (int a = 0; a < 512; a++) put(a, pat(a, 4));
        for (int a = 0; a < 512; a++) begin
            get_async(a, v);
            check($sformatf("R1 shape11 async a=%0d", a), v, expect_word(3, a));
        end

        // R2: write enable low, address and data driven, nothing changes
        set_shape(1);
        @(negedge wr_clk);
        wr_addr = 9'd5;
        wr_data = ~{9'h0, expect_word(1, 5)[8:0]};
        repeat (3) @(negedge wr_clk);
        get_async(5, v);
        check("R2 no write with enable low", v, expect_word(1, 5));

        // R9: combinational read follows an address change without a read clock
        get_async(7, v);
        check("R9 async follows address a=7", v, expect_word(1, 7));
        get_async(8, v);
        check("R9 async follows address a=8", v, expect_word(1, 8));

        // R10 R9: write under a steady combinational read address
        rd_addr = 9'd12;
        put(12, 18'h0015A);
        #0.5;
        check("R10 R9 async shows new write", rd_data, 18'h0015A);
        rd_async = 1'b0;

        // R8: registered read holds through address change and a write to its word
        get_sync(10, keep);
        check("R7 sync load a=10", keep, expect_word(1, 10));
        @(negedge rd_clk);
        rd_addr = 9'd20;
        put(10, keep ^ 18'h001FF);
        repeat (3) @(negedge rd_clk);
        check("R8 hold with enable low", rd_data, keep);

        // R10: read after write returns new data
        get_sync(10, v);
        check("R10 read after write a=10", v, keep ^ 18'h001FF);
        put(33, 18'h000A5);
        get_sync(33, v);
        check("R10 read after write a=33", v, 18'h000A5);

        // R11: mid-run reset clears only the read register
        @(negedge rd_clk);
        rst_n = 1'b0;
        #0.5;
        check("R11 reset clears during run", rd_data, 18'h0);
        @(negedge rd_clk);
        rst_n = 1'b1;
        get_sync(33, v);
        check("R11 array kept through reset", v, 18'h000A5);

        finish_up();
    end

endmodule